// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer and Refresh Scheduler

This block brings a single-rank, 16-bit wide SDRAM with four internal banks (12 row bits, 8 column bits) out of reset and then keeps it refreshed. After reset it raises clock-enable and waits a programmable settling time. It then issues a precharge to all banks, a burst of eight auto-refresh commands and a mode-register load whose value comes from a configuration input. Each step respects cycle-count timings given as parameters.

Once initialization ends, an interval counter requests an auto-refresh at a fixed period. A single-beat user port shares the command bus with these refreshes. Each user access opens a row, performs one read or write on a column, and closes the row with a precharge. A pending refresh wins over a new request but never cuts into an access that has already started.

The memory clock is the controller clock divided by two. One SDRAM cycle spans two controller cycles, and every timing parameter is counted in SDRAM cycles.

Top module: `sdr_init_refresh_ctrl`

## Requirements
- R1: During and after reset until the first SDRAM cycle, `sd_cke` is low, the command on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} is NOP (4'b0111), and `req_ready` and `init_done` are low.
- R2: Initialization runs in a fixed order, each command lasting one SDRAM cycle:
  - `sd_cke` rises.
  - Exactly INIT_WAIT SDRAM cycles later, PRECHARGE (4'b0010) is issued with `sd_addr[10]` high.
  - Eight AUTO-REFRESH commands (4'b0001) follow.
  - LOAD-MODE (4'b0000) is issued with `sd_addr` equal to `mode_cfg` and `sd_ba` zero.
  - `init_done` then goes high.
- R3: During initialization, the precharge-to-first-refresh gap is exactly T_RP SDRAM cycles. The gap between consecutive refreshes, and between the last refresh and LOAD-MODE, is exactly T_RC. The first command after LOAD-MODE comes at least T_MRD cycles later.
- R4: `req_ready` stays low and no ACTIVE command (4'b0011) is issued until `init_done` is high.
- R5: `req_addr` maps as bank `[21:20]`, row `[19:8]` and column `[7:0]`. An accepted request issues ACTIVE with that bank on `sd_ba` and that row on `sd_addr`. READ (4'b0101) or WRITE (4'b0100) follows exactly T_RCD cycles later, with the column on `sd_addr[7:0]` and `sd_addr[10]` low.
- R6: A write drives `req_wdata` on `sd_dq_out`, with `sd_dq_oe` high, during the WRITE cycle only. A single-bank PRECHARGE (`sd_addr[10]` low, same bank) follows max(T_WR, T_RAS−T_RCD) cycles after the WRITE.
- R7: A read samples `sd_dq_in` at the end of SDRAM cycle READ+CAS_LAT−1. The sampled word appears on `rd_data` while `rd_valid` is high for exactly one controller cycle. PRECHARGE is issued CAS_LAT cycles after the READ.
- R8: Any two ACTIVE/AUTO-REFRESH commands are at least T_RC cycles apart. ACTIVE-to-PRECHARGE on a row is at least T_RAS cycles.
- R9: After initialization, a refresh falls due every REF_INTERVAL SDRAM cycles. While one is due, `req_ready` is low and the refresh is issued before any new access. Consecutive refreshes stay within REF_INTERVAL±12 cycles even under a continuous request stream.
- R10: No AUTO-REFRESH is issued between an access's ACTIVE and its PRECHARGE.
- R11: `sd_clk` toggles on every controller clock edge. Commands change only at the controller edge that ends an SDRAM cycle (the edge where `sd_clk` falls).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 12 | Value driven on the address lines for LOAD-MODE |
| req_valid | input | 1 | User request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data |
| init_done | output | 1 | Initialization finished |
| sd_clk | output | 1 | Memory clock, half the controller rate |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Command bit 3 |
| sd_ras_n | output | 1 | Command bit 2 |
| sd_cas_n | output | 1 | Command bit 1 |
| sd_we_n | output | 1 | Command bit 0 |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / mode address |
| sd_dq_out | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Read data from memory |

## Verification
A memory model on the command bus records every command with its SDRAM cycle number. It stores written words and returns read data CAS_LAT cycles after each READ. The startup log is checked against the exact order and spacing. A table of writes and reads covers the corner banks and rows, the extreme columns and an overwrite, which separates wrong address slicing from wrong data paths. A long back-to-back read stream shows whether refresh keeps its period and priority under load, and whether an access is ever split by a refresh.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_STAB, ST_PALL, ST_IREF, ST_MRS,
    ST_IDLE, ST_ACT, ST_RD, ST_WR, ST_PRE, ST_REF
  } sdr_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles between a precharge and the next activate, given the row age at precharge.
  function automatic int unsigned pre_gap(input int unsigned t_rp, input int unsigned t_rc,
                                          input int unsigned age);
    return max_u(t_rp, (t_rc > age) ? (t_rc - age) : 0);
  endfunction

  // Cycles from WRITE to PRECHARGE, honouring both recovery and minimum row-open time.
  function automatic int unsigned wr_hold(input int unsigned t_wr, input int unsigned t_ras,
                                          input int unsigned t_rcd);
    return max_u(t_wr, (t_ras > t_rcd) ? (t_ras - t_rcd) : 1);
  endfunction
endpackage

// File: rtl/sdr_phase_gen.sv
module sdr_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic sd_clk,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign sd_clk = phase_q;
  assign tick   = phase_q;   // the next edge closes the current SDRAM cycle
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int unsigned REF_INTERVAL = 683
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  localparam int unsigned RW = $clog2(REF_INTERVAL + 1);
  logic [RW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RW'(REF_INTERVAL - 1);
      pend_q <= 1'b0;
    end else if (tick) begin
      if (ack) pend_q <= 1'b0;
      if (enable) begin
        if (cnt_q == '0) begin
          cnt_q  <= RW'(REF_INTERVAL - 1);
          pend_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
  import sdr_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned DQ_W      = 16,
  parameter int unsigned INIT_WAIT = 100,
  parameter int unsigned INIT_REFS = 8,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_RC      = 7,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_RAS     = 4,
  parameter int unsigned CAS_LAT   = 3,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [ROW_W-1:0] mode_cfg,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [BA_W-1:0]  req_ba,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [DQ_W-1:0]  req_wdata,
  input  logic             ref_pend,
  output logic             ref_ack,
  output logic             req_ready,
  output logic             init_done,
  output logic             rd_valid,
  output logic [DQ_W-1:0]  rd_data,
  output logic             cke,
  output logic [3:0]       cmd,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  input  logic [DQ_W-1:0]  dq_in
);
  localparam int unsigned AP_BIT      = 10;
  localparam int unsigned NR_W        = $clog2(INIT_REFS + 1);
  localparam int unsigned WR_TO_PRE   = wr_hold(T_WR, T_RAS, T_RCD);
  localparam int unsigned PRE_WAIT_WR = pre_gap(T_RP, T_RC, T_RCD + WR_TO_PRE);
  localparam int unsigned PRE_WAIT_RD = pre_gap(T_RP, T_RC, T_RCD + CAS_LAT);
  localparam logic [ROW_W-1:0] AP_ADDR = ROW_W'(1) << AP_BIT;

  sdr_state_e        st_q;
  sdr_cmd_e          cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NR_W-1:0]   nref_q;
  logic              cke_q, done_q, oe_q, we_q, rdv_q;
  logic [BA_W-1:0]   ba_q;
  logic [ROW_W-1:0]  addr_q;
  logic [COL_W-1:0]  col_q;
  logic [DQ_W-1:0]   wd_q, dqo_q, rdd_q;
  logic              cnt_zero, idle_free;

  assign cnt_zero  = (cnt_q == '0);
  assign idle_free = (st_q == ST_IDLE) && !ref_pend;
  assign req_ready = idle_free && tick;
  assign ref_ack   = tick && (st_q == ST_IDLE) && ref_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_PWR;  cmd_q <= CMD_NOP;  cnt_q <= '0;  nref_q <= '0;
      cke_q <= 1'b0;   done_q <= 1'b0;    oe_q <= 1'b0; we_q <= 1'b0;
      rdv_q <= 1'b0;   ba_q <= '0;        addr_q <= '0; col_q <= '0;
      wd_q <= '0;      dqo_q <= '0;       rdd_q <= '0;
    end else begin
      rdv_q <= 1'b0;
      if (tick) begin
        cmd_q <= CMD_NOP;
        oe_q  <= 1'b0;
        if (!cnt_zero && st_q != ST_IDLE && st_q != ST_PWR) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          unique case (st_q)
            ST_PWR: begin
              cke_q <= 1'b1;
              cnt_q <= CNT_W'(INIT_WAIT - 1);
              st_q  <= ST_STAB;
            end
            ST_STAB: begin
              cmd_q  <= CMD_PRE;
              addr_q <= AP_ADDR;
              cnt_q  <= CNT_W'(T_RP - 1);
              st_q   <= ST_PALL;
            end
            ST_PALL: begin
              cmd_q  <= CMD_REF;
              nref_q <= NR_W'(1);
              cnt_q  <= CNT_W'(T_RC - 1);
              st_q   <= ST_IREF;
            end
            ST_IREF: begin
              if (nref_q == NR_W'(INIT_REFS)) begin
                cmd_q  <= CMD_LMR;
                addr_q <= mode_cfg;
                ba_q   <= '0;
                cnt_q  <= CNT_W'(T_MRD - 1);
                st_q   <= ST_MRS;
              end else begin
                cmd_q  <= CMD_REF;
                nref_q <= nref_q + 1'b1;
                cnt_q  <= CNT_W'(T_RC - 1);
              end
            end
            ST_MRS: begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
            ST_IDLE: begin
              if (ref_pend) begin
                cmd_q <= CMD_REF;
                cnt_q <= CNT_W'(T_RC - 1);
                st_q  <= ST_REF;
              end else if (req_valid) begin
                cmd_q  <= CMD_ACT;
                ba_q   <= req_ba;
                addr_q <= req_row;
                col_q  <= req_col;
                we_q   <= req_we;
                wd_q   <= req_wdata;
                cnt_q  <= CNT_W'(T_RCD - 1);
                st_q   <= ST_ACT;
              end
            end
            ST_ACT: begin
              addr_q <= ROW_W'(col_q);
              if (we_q) begin
                cmd_q <= CMD_WR;
                dqo_q <= wd_q;
                oe_q  <= 1'b1;
                cnt_q <= CNT_W'(WR_TO_PRE - 1);
                st_q  <= ST_WR;
              end else begin
                cmd_q <= CMD_RD;
                cnt_q <= CNT_W'(CAS_LAT - 1);
                st_q  <= ST_RD;
              end
            end
            ST_WR: begin
              cmd_q  <= CMD_PRE;
              addr_q <= '0;
              cnt_q  <= CNT_W'(PRE_WAIT_WR - 1);
              st_q   <= ST_PRE;
            end
            ST_RD: begin
              rdd_q  <= dq_in;
              rdv_q  <= 1'b1;
              cmd_q  <= CMD_PRE;
              addr_q <= '0;
              cnt_q  <= CNT_W'(PRE_WAIT_RD - 1);
              st_q   <= ST_PRE;
            end
            ST_PRE, ST_REF: st_q <= ST_IDLE;
            default:        st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign init_done = done_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign cke       = cke_q;
  assign cmd       = cmd_q;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign dq_out    = dqo_q;
  assign dq_oe     = oe_q;
endmodule

// File: rtl/sdr_init_refresh_ctrl.sv
module sdr_init_refresh_ctrl #(
  parameter int unsigned BA_W         = 2,
  parameter int unsigned ROW_W        = 12,
  parameter int unsigned COL_W        = 8,
  parameter int unsigned DQ_W         = 16,
  parameter int unsigned INIT_WAIT    = 100,
  parameter int unsigned INIT_REFS    = 8,
  parameter int unsigned T_RP         = 2,
  parameter int unsigned T_RC         = 7,
  parameter int unsigned T_MRD        = 2,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned T_WR         = 2,
  parameter int unsigned T_RAS        = 4,
  parameter int unsigned CAS_LAT      = 3,
  parameter int unsigned REF_INTERVAL = 683
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ROW_W-1:0]              mode_cfg,
  input  logic                          req_valid,
  input  logic                          req_we,
  input  logic [BA_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]               req_wdata,
  output logic                          req_ready,
  output logic                          rd_valid,
  output logic [DQ_W-1:0]               rd_data,
  output logic                          init_done,
  output logic                          sd_clk,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BA_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DQ_W-1:0]               sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DQ_W-1:0]               sd_dq_in
);
  localparam int unsigned ADDR_W = BA_W + ROW_W + COL_W;
  localparam int unsigned CNT_W  = $clog2(INIT_WAIT + 64);

  // Named internal events, also used by the bound checker
  logic       tick_w;
  logic       ref_pend_w;
  logic       ref_ack_w;
  logic [3:0] cmd_w;

  sdr_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk), .tick(tick_w)
  );

  sdr_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_rtmr (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .enable(init_done),
    .ack(ref_ack_w), .pending(ref_pend_w)
  );

  sdr_cmd_seq #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .INIT_WAIT(INIT_WAIT), .INIT_REFS(INIT_REFS), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .T_RCD(T_RCD), .T_WR(T_WR), .T_RAS(T_RAS),
    .CAS_LAT(CAS_LAT), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .mode_cfg(mode_cfg),
    .req_valid(req_valid), .req_we(req_we),
    .req_ba(req_addr[ADDR_W-1 -: BA_W]),
    .req_row(req_addr[COL_W +: ROW_W]),
    .req_col(req_addr[COL_W-1:0]),
    .req_wdata(req_wdata), .ref_pend(ref_pend_w), .ref_ack(ref_ack_w),
    .req_ready(req_ready), .init_done(init_done),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cke(sd_cke), .cmd(cmd_w), .ba(sd_ba), .addr(sd_addr),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe), .dq_in(sd_dq_in)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_w;
endmodule

// File: rtl/sdr_ctrl_checker.sv
module sdr_ctrl_checker
  import sdr_pkg::*;
#(
  parameter int unsigned T_RC  = 7,
  parameter int unsigned T_RCD = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cke,
  input logic [3:0] cmd,
  input logic       init_done,
  input logic       req_ready,
  input logic       ref_pend,
  input logic       rd_valid
);
  logic [7:0] rc_age_q, act_age_q;
  logic       is_rc, is_col;

  assign is_rc  = (cmd == CMD_ACT) || (cmd == CMD_REF);
  assign is_col = (cmd == CMD_RD)  || (cmd == CMD_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_age_q  <= 8'hFF;
      act_age_q <= 8'hFF;
    end else if (tick) begin
      rc_age_q  <= is_rc ? 8'd1 : ((rc_age_q == 8'hFF) ? rc_age_q : rc_age_q + 8'd1);
      act_age_q <= (cmd == CMD_ACT) ? 8'd1
                 : ((act_age_q == 8'hFF) ? act_age_q : act_age_q + 8'd1);
    end
  end

  a_r1_nop_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd == CMD_NOP);

  a_r4_no_ready_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);

  a_r9_refresh_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

  a_r11_cmd_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd) |-> $past(tick));

  a_r8_row_cycle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && is_rc) |-> rc_age_q >= 8'(T_RC));

  a_r5_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && is_col) |-> act_age_q >= 8'(T_RCD));

  a_r7_rd_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind sdr_init_refresh_ctrl sdr_ctrl_checker #(.T_RC(T_RC), .T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .cke(sd_cke), .cmd(cmd_w),
  .init_done(init_done), .req_ready(req_ready), .ref_pend(ref_pend_w),
  .rd_valid(rd_valid)
);

// File: tb/sim_sdr_init_refresh_ctrl.sv
module sim_sdr_init_refresh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_WAIT = 100, T_RP = 2, T_RC = 7, T_MRD = 2, T_RCD = 2;
  localparam int T_WR = 2, T_RAS = 4, CL = 3, RI = 683;
  localparam int WR_PRE = (T_WR > T_RAS - T_RCD) ? T_WR : T_RAS - T_RCD;
  localparam logic [11:0] MODE = 12'h232;
  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;
  localparam int LOGN = 1024;
  localparam int NV = 12;
  // {we, addr[21:0], data[15:0]}; for reads data is the expected word
  localparam logic [38:0] TBL [NV] = '{
    {1'b1, 22'h000000, 16'hA5A5}, {1'b1, 22'h1ABC5F, 16'hC3C3},
    {1'b1, 22'h3FFFFF, 16'h0001}, {1'b1, 22'h212380, 16'hFFFF},
    {1'b1, 22'h000001, 16'h1234}, {1'b0, 22'h000000, 16'hA5A5},
    {1'b0, 22'h1ABC5F, 16'hC3C3}, {1'b0, 22'h3FFFFF, 16'h0001},
    {1'b1, 22'h000000, 16'h5A5A}, {1'b0, 22'h000000, 16'h5A5A},
    {1'b0, 22'h212380, 16'hFFFF}, {1'b0, 22'h000001, 16'h1234}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, init_done, sd_clk, sd_cke;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out, sd_dq_in;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;
  logic [3:0] bus_cmd;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_init_refresh_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_cfg(MODE), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .init_done(init_done), .sd_clk(sd_clk), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  assign bus_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // ---------------- memory model and command log ----------------
  logic [15:0] mem [int];
  logic [11:0] open_row [4];
  logic [3:0]  ev_cmd [LOGN];
  int          ev_cyc [LOGN];
  logic [11:0] ev_addr [LOGN];
  logic [1:0]  ev_ba [LOGN];
  int ev_n = 0, sdcyc = 0, cke_cyc = -1, oe_bad = 0;
  logic rp_v0 = 0, rp_v1 = 0, rp_v2 = 0;
  logic [15:0] rp_d0 = '0, rp_d1 = '0, rp_d2 = '0;

  assign sd_dq_in = rp_v2 ? rp_d2 : 16'hDEAD;

  always @(posedge sd_clk) begin
    int key;
    logic [15:0] rdw;
    rdw = 16'h0000;
    if (sd_cke && cke_cyc < 0) cke_cyc = sdcyc;
    if ((bus_cmd == C_WR) != sd_dq_oe) oe_bad++;
    if (bus_cmd != C_NOP && ev_n < LOGN) begin
      ev_cmd[ev_n] = bus_cmd; ev_cyc[ev_n] = sdcyc;
      ev_addr[ev_n] = sd_addr; ev_ba[ev_n] = sd_ba;
      ev_n++;
    end
    key = int'({sd_ba, open_row[sd_ba], sd_addr[7:0]});
    if (bus_cmd == C_ACT) open_row[sd_ba] = sd_addr;
    if (bus_cmd == C_WR) mem[key] = sd_dq_out;
    if (bus_cmd == C_RD && mem.exists(key)) rdw = mem[key];
    rp_v2 = rp_v1; rp_d2 = rp_d1;
    rp_v1 = rp_v0; rp_d1 = rp_d0;
    rp_v0 = (bus_cmd == C_RD); rp_d0 = rdw;
    sdcyc++;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_req(input logic we, input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rd(output logic [15:0] d, output bit got);
    got = 0; d = '0;
    for (int i = 0; i < 100 && !got; i++) begin
      if (rd_valid) begin got = 1; d = rd_data; end
      else @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int bad, ev_start, k, nref, prev_ref, cnt_sd;
    logic [15:0] d;
    bit got;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sd_cke == 1'b0, "R1 cke low in reset", sd_cke, 0);
    chk(bus_cmd == C_NOP, "R1 NOP in reset", bus_cmd, C_NOP);
    chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
    chk(init_done == 1'b0, "R1 init_done low in reset", init_done, 0);
    rst_n = 1'b1;

    // R11: half-rate memory clock
    cnt_sd = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (sd_clk) cnt_sd++;
    end
    chk(cnt_sd == 50, "R11 sd_clk half rate", cnt_sd, 50);

    // R4: request held during init is refused
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 22'h000000; req_wdata = 16'h1111;
    bad = 0;
    while (!init_done) begin
      if (req_ready) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R4 ready low during init", bad, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    repeat (40) @(negedge clk);

    // R2/R3: init log
    chk(ev_cmd[0] == C_PRE && ev_addr[0][10], "R2 first command precharge-all", ev_cmd[0], C_PRE);
    chk(ev_cyc[0] - cke_cyc == INIT_WAIT, "R2 settle wait", ev_cyc[0] - cke_cyc, INIT_WAIT);
    bad = 0;
    for (int i = 1; i <= 8; i++) if (ev_cmd[i] != C_REF) bad++;
    chk(bad == 0, "R2 eight init refreshes", bad, 0);
    chk(ev_cmd[9] == C_LMR && ev_addr[9] == MODE && ev_ba[9] == 2'd0,
        "R2 load-mode with mode_cfg", ev_addr[9], MODE);
    chk(ev_cyc[1] - ev_cyc[0] == T_RP, "R3 tRP after precharge", ev_cyc[1] - ev_cyc[0], T_RP);
    bad = 0;
    for (int i = 2; i <= 9; i++) if (ev_cyc[i] - ev_cyc[i-1] != T_RC) bad++;
    chk(bad == 0, "R3 tRC spacing in init", bad, 0);
    chk(ev_cmd[10] == C_ACT && ev_cyc[10] - ev_cyc[9] >= T_MRD, "R3 tMRD after load-mode",
        ev_cyc[10] - ev_cyc[9], T_MRD);

    // Table of vectors
    ev_start = ev_n;
    for (int v = 0; v < NV; v++) begin
      do_req(TBL[v][38], TBL[v][37:16], TBL[v][15:0]);
      if (!TBL[v][38]) begin
        wait_rd(d, got);
        chk(got && d == TBL[v][15:0], "R7 read data", d, TBL[v][15:0]);
      end
      repeat (4) @(negedge clk);
    end
    // R5: bank/row on ACTIVE, column on READ/WRITE
    k = 0; bad = 0;
    for (int i = ev_start; i < ev_n && k < NV; i++) begin
      if (ev_cmd[i] == C_ACT) begin
        if (ev_ba[i] != TBL[k][37:36] || ev_addr[i] != TBL[k][35:24] ||
            ev_addr[i+1][7:0] != TBL[k][23:16] ||
            ev_cmd[i+1] != (TBL[k][38] ? C_WR : C_RD)) bad++;
        k++;
      end
    end
    chk(bad == 0 && k == NV, "R5 address mapping", bad, 0);

    // Continuous read stream to exercise refresh under load
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      do_req(1'b0, 22'h1ABC5F, 16'h0);
      wait_rd(d, got);
      if (!got || d != 16'hC3C3) bad++;
    end
    chk(bad == 0, "R7 stream read data", bad, 0);
    repeat (20) @(negedge clk);

    // Log scan: access shapes
    begin
      int e5 = 0, e6 = 0, e7 = 0, e10 = 0, e8 = 0, last_rc = -1000;
      for (int i = 10; i < ev_n; i++) begin
        if (ev_cmd[i] == C_ACT || ev_cmd[i] == C_REF) begin
          if (ev_cyc[i] - last_rc < T_RC) e8++;
          last_rc = ev_cyc[i];
        end
        if (ev_cmd[i] == C_ACT && i + 2 < ev_n) begin
          if ((ev_cmd[i+1] != C_RD && ev_cmd[i+1] != C_WR) ||
              ev_cyc[i+1] - ev_cyc[i] != T_RCD || ev_addr[i+1][10]) e5++;
          if (ev_cmd[i+2] != C_PRE || ev_ba[i+2] != ev_ba[i]) e10++;
          if (ev_cyc[i+2] - ev_cyc[i] < T_RAS) e8++;
          if (ev_cmd[i+1] == C_WR &&
              (ev_cyc[i+2] - ev_cyc[i+1] != WR_PRE || ev_addr[i+2][10])) e6++;
          if (ev_cmd[i+1] == C_RD && ev_cyc[i+2] - ev_cyc[i+1] != CL) e7++;
        end
      end
      chk(e5 == 0, "R5 tRCD and column command", e5, 0);
      chk(e6 == 0 && oe_bad == 0, "R6 write precharge and data enable", e6 + oe_bad, 0);
      chk(e7 == 0, "R7 read precharge timing", e7, 0);
      chk(e10 == 0, "R10 access not split by refresh", e10, 0);
      chk(e8 == 0, "R8 tRC and tRAS", e8, 0);
    end

    // R9: periodic refresh after init
    nref = 0; prev_ref = -1; bad = 0;
    for (int i = 10; i < ev_n; i++) begin
      if (ev_cmd[i] == C_REF) begin
        if (prev_ref >= 0 &&
            (ev_cyc[i] - prev_ref < RI - 12 || ev_cyc[i] - prev_ref > RI + 12)) bad++;
        prev_ref = ev_cyc[i];
        nref++;
      end
    end
    chk(nref >= 3, "R9 refreshes under load", nref, 3);
    chk(bad == 0, "R9 refresh period", bad, 0);
    chk(ev_n < LOGN, "R9 log capacity", ev_n, LOGN);

    finish_run();
  end
endmodule